// File: doc/BRIEF.md
# In-Order Retire Queue

This block keeps the macro-ops of an out-of-order core in program order from dispatch until they leave the machine. Dispatch writes one macro-op per cycle into the tail of its thread's region, tagged with an end-of-instruction flag and the physical register tag the macro-op displaced. Integer and floating-point execution report completion, with or without a fault, by entry index. Each cycle the queue retires a group of up to `RW` macro-ops from the head of one thread and returns their displaced tags so those registers can be freed.

Retirement works on whole instructions. An instruction may span several macro-ops and leaves only when every one of them has completed cleanly; a group never ends in the middle of an instruction. When the oldest instruction of a thread contains a faulted macro-op, the queue reports it with the entry index, retires nothing in that cycle and discards every entry of that thread. Dispatch may also discard a thread's entries on its own. With two threads active the storage is split into two fixed halves; with one thread, thread 0 owns all of it.

Top module: `retire_queue`

## Requirements
- R1: An accepted allocation writes the entry at index base + tail of its thread (base 0 for thread 0), and successive accepted allocations of a thread take consecutive indices, wrapping inside the thread's region.
- R2: With `smtMode` high, each thread holds at most `DEPTH/2` entries (112 by default); thread 0 uses indices 0 to 111 and thread 1 starts at index 112; `allocReady` is low for a thread whose half is full.
- R3: With `smtMode` low, thread 0 may hold all `DEPTH` entries (224 by default) and `allocReady` is always low for thread 1.
- R4: A completion report is dropped if its entry is not occupied at that clock edge, including an entry being allocated on the same edge.
- R5: A macro-op retires only as part of an instruction whose macro-ops all completed without fault; the last macro-op retired in a cycle always carries the end-of-instruction flag.
- R6: Retired macro-ops appear on the lowest slots of `retValid` (a contiguous run from slot 0) in allocation order, each with the displaced tag given at allocation.
- R7: At most `RW` (8) macro-ops retire per cycle; a cycle's group stops before the first instruction that is incomplete or would not fit whole, so two 5-op instructions retire as 5 then 5.
- R8: When the oldest instruction of the chosen thread has a faulted macro-op whose earlier macro-ops in that instruction all completed, `excValid` rises with that entry's index and thread, nothing retires that cycle, and the thread's entries are discarded so its next allocation lands at its region base.
- R9: A discard request for one thread empties that thread's region and resets its next index to the region base, leaving the other thread's entries and indices untouched.
- R10: Only one thread retires or reports per cycle; when both have work, the threads alternate, starting with thread 0 after reset.
- R11: After reset the queue is empty: `retValid` is zero, `excValid` is low, and thread 0 is ready with next index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| smtMode | input | 1 | High: two threads, storage halved; change only during reset |
| allocValid | input | 1 | Dispatch offers a macro-op |
| allocThread | input | 1 | Thread of the offered macro-op |
| allocEnd | input | 1 | Offered macro-op closes its instruction |
| allocPrevTag | input | TAGW | Physical tag displaced by the macro-op |
| allocReady | output | 1 | Offer is accepted on this edge |
| allocIdx | output | IDXW | Entry index the offer is written to |
| cmplValid | input | NCMP | Completion strobes, one per execution source |
| cmplIdx | input | NCMP x IDXW | Entry index per completion source |
| cmplExc | input | NCMP | Completion carries a fault |
| flushValid | input | 1 | Discard one thread's entries |
| flushThread | input | 1 | Thread to discard |
| retValid | output | RW | Retire slot valid, contiguous from slot 0 |
| retPrevTag | output | RW x TAGW | Displaced tag of each retiring macro-op |
| retThread | output | 1 | Thread owning this cycle's retire group |
| excValid | output | 1 | Oldest instruction faulted; thread is discarded |
| excThread | output | 1 | Thread of the fault |
| excIdx | output | IDXW | Entry index of the faulted macro-op |

## Verification
The grouping logic is driven with instruction shapes that vary length and completion pattern: single-op runs longer than the retire width separate the per-cycle cap from the boundary rule, a pair of five-op instructions shows the group stopping at a boundary rather than filling eight slots, and a missing completion inside or before an instruction shows that nothing past the gap leaves. Completions are issued from youngest to oldest so that a whole window becomes ready on one edge, making the per-cycle count visible. Directed cases cover a fault that becomes oldest only after an earlier macro-op completes, a completion racing its own allocation, region fill in both thread modes, and retire alternation and per-thread discard with two threads.

// File: rtl/rq_pkg.sv
package rq_pkg;

  // Strobes from control to the entry store.
  typedef struct packed {
    logic allocWe;  // write the offered macro-op at allocIdx
    logic flushLo;  // clear thread 0 region (whole store in single-thread mode)
    logic flushHi;  // clear thread 1 region
    logic retThr;   // thread whose window is retired / read for tags
  } rqStrobe_t;

endpackage

// File: rtl/rq_data.sv
module rq_data
  import rq_pkg::*;
#(
  parameter int DEPTH = 224,
  parameter int RW    = 8,
  parameter int NCMP  = 2,
  parameter int TAGW  = 8,
  parameter int IDXW  = 8,
  parameter int HALF  = 112
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                smtMode,
  input  rqStrobe_t                           st,
  input  logic [IDXW-1:0]                     allocIdx,
  input  logic                                allocEnd,
  input  logic [TAGW-1:0]                     allocTag,
  input  logic [1:0][RW-1:0][IDXW-1:0]        winIdx,
  input  logic [RW-1:0]                       retMask,
  input  logic [NCMP-1:0]                     cmplValid,
  input  logic [NCMP-1:0][IDXW-1:0]           cmplIdx,
  input  logic [NCMP-1:0]                     cmplExc,
  output logic [1:0][RW-1:0]                  winOk,
  output logic [1:0][RW-1:0]                  winExc,
  output logic [1:0][RW-1:0]                  winEnd,
  output logic [RW-1:0][TAGW-1:0]             retTag
);

  logic [DEPTH-1:0]            valid;
  logic [DEPTH-1:0]            done;
  logic [DEPTH-1:0]            exc;
  logic [DEPTH-1:0]            endm;
  logic [DEPTH-1:0][TAGW-1:0]  tag;

  // Window status for both threads, tags for the retiring thread.
  always_comb begin
    for (int t = 0; t < 2; t++) begin
      for (int k = 0; k < RW; k++) begin
        winOk[t][k]  = valid[winIdx[t][k]] & done[winIdx[t][k]] & ~exc[winIdx[t][k]];
        winExc[t][k] = valid[winIdx[t][k]] & done[winIdx[t][k]] &  exc[winIdx[t][k]];
        winEnd[t][k] = endm[winIdx[t][k]];
      end
    end
    for (int k = 0; k < RW; k++) begin
      retTag[k] = tag[winIdx[st.retThr][k]];
    end
  end

  // Write order: completion, retire clear, flush clear, allocation (last wins).
  always_ff @(posedge clk) begin
    if (!rstN) begin
      valid <= '0;
      done  <= '0;
      exc   <= '0;
      endm  <= '0;
      tag   <= '0;
    end else begin
      for (int c = 0; c < NCMP; c++) begin
        if (cmplValid[c] && (int'(cmplIdx[c]) < DEPTH) && valid[cmplIdx[c]]) begin
          done[cmplIdx[c]] <= 1'b1;
          exc[cmplIdx[c]]  <= exc[cmplIdx[c]] | cmplExc[c];
        end
      end
      for (int k = 0; k < RW; k++) begin
        if (retMask[k]) valid[winIdx[st.retThr][k]] <= 1'b0;
      end
      for (int i = 0; i < DEPTH; i++) begin
        if ((st.flushLo && (!smtMode || i < HALF)) || (st.flushHi && i >= HALF))
          valid[i] <= 1'b0;
      end
      if (st.allocWe) begin
        valid[allocIdx] <= 1'b1;
        done[allocIdx]  <= 1'b0;
        exc[allocIdx]   <= 1'b0;
        endm[allocIdx]  <= allocEnd;
        tag[allocIdx]   <= allocTag;
      end
    end
  end

  // R1
  free_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.allocWe |-> !valid[allocIdx]);

  for (genvar k = 0; k < RW; k++) begin : g_retChk
    // R5
    ret_done_chk: assert property (@(posedge clk) disable iff (!rstN)
      retMask[k] |-> (valid[winIdx[st.retThr][k]] && done[winIdx[st.retThr][k]]
                      && !exc[winIdx[st.retThr][k]]));
  end

endmodule

// File: rtl/rq_ctrl.sv
module rq_ctrl
  import rq_pkg::*;
#(
  parameter int DEPTH = 224,
  parameter int RW    = 8,
  parameter int IDXW  = 8,
  parameter int HALF  = 112,
  parameter int CW    = 4,
  parameter int PW    = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          smtMode,
  input  logic                          allocValid,
  input  logic                          allocThread,
  output logic                          allocReady,
  output logic [IDXW-1:0]               allocIdx,
  input  logic                          flushValid,
  input  logic                          flushThread,
  input  logic [1:0][RW-1:0]            winOk,
  input  logic [1:0][RW-1:0]            winExc,
  input  logic [1:0][RW-1:0]            winEnd,
  output logic [1:0][RW-1:0][IDXW-1:0]  winIdx,
  output logic [RW-1:0]                 retMask,
  output rqStrobe_t                     st,
  output logic                          excValid,
  output logic [IDXW-1:0]               excIdx
);

  logic [1:0][IDXW-1:0] headQ, tailQ, headD, tailD;
  logic [1:0][IDXW:0]   cntQ, cntD;
  logic                 rrQ;

  logic [1:0][CW-1:0]   nRet;
  logic [1:0]           excHit, act, flushNow;
  logic [1:0][PW-1:0]   excPos;
  logic                 sel, doRet, allocWe, capOk;
  logic [IDXW:0]        sizeV;

  always_comb begin
    logic [IDXW:0] off, hs, ts;
    logic [CW-1:0] retN;
    logic          stop, occ, al;

    sizeV = smtMode ? (IDXW+1)'(HALF) : (IDXW+1)'(DEPTH);

    // Head windows and per-thread group scan.
    for (int t = 0; t < 2; t++) begin
      nRet[t]   = '0;
      excHit[t] = 1'b0;
      excPos[t] = '0;
      stop      = 1'b0;
      for (int k = 0; k < RW; k++) begin
        off = {1'b0, headQ[t]} + (IDXW+1)'(k);
        if (off >= sizeV) off = off - sizeV;
        winIdx[t][k] = IDXW'((t == 1 ? HALF : 0) + int'(off));
        occ = (IDXW+1)'(k) < cntQ[t];
        if (!stop) begin
          if (occ && winOk[t][k]) begin
            if (winEnd[t][k]) nRet[t] = CW'(k + 1);
          end else begin
            stop = 1'b1;
            if (nRet[t] == '0 && occ && winExc[t][k]) begin
              excHit[t] = 1'b1;
              excPos[t] = PW'(k);
            end
          end
        end
      end
      act[t] = (nRet[t] != '0 || excHit[t]) && !(flushValid && flushThread == 1'(t));
    end

    // One thread per cycle, alternating priority.
    sel      = act[rrQ] ? rrQ : ~rrQ;
    excValid = act[sel] && excHit[sel];
    doRet    = act[sel] && !excHit[sel];
    for (int k = 0; k < RW; k++) retMask[k] = doRet && (CW'(k) < nRet[sel]);
    excIdx = winIdx[sel][excPos[sel]];

    for (int t = 0; t < 2; t++)
      flushNow[t] = (flushValid && flushThread == 1'(t)) || (excValid && sel == 1'(t));

    capOk      = smtMode ? (cntQ[allocThread] < (IDXW+1)'(HALF))
                         : (!allocThread && cntQ[0] < (IDXW+1)'(DEPTH));
    allocReady = capOk && !flushNow[allocThread];
    allocWe    = allocValid && allocReady;
    allocIdx   = IDXW'((allocThread ? HALF : 0) + int'(tailQ[allocThread]));

    st.allocWe = allocWe;
    st.flushLo = flushNow[0];
    st.flushHi = flushNow[1];
    st.retThr  = sel;

    // Pointer and occupancy update.
    for (int t = 0; t < 2; t++) begin
      retN = (doRet && sel == 1'(t)) ? nRet[t] : '0;
      al   = allocWe && allocThread == 1'(t);
      hs   = {1'b0, headQ[t]} + (IDXW+1)'(retN);
      if (hs >= sizeV) hs = hs - sizeV;
      ts   = {1'b0, tailQ[t]} + (IDXW+1)'(1);
      if (ts >= sizeV) ts = '0;
      if (flushNow[t]) begin
        headD[t] = '0;
        tailD[t] = '0;
        cntD[t]  = '0;
      end else begin
        headD[t] = IDXW'(hs);
        tailD[t] = al ? IDXW'(ts) : tailQ[t];
        cntD[t]  = cntQ[t] + (IDXW+1)'(al) - (IDXW+1)'(retN);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ <= '0;
      tailQ <= '0;
      cntQ  <= '0;
      rrQ   <= 1'b0;
    end else begin
      headQ <= headD;
      tailQ <= tailD;
      cntQ  <= cntD;
      if (|act) rrQ <= ~sel;
    end
  end

  // R2
  half_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    smtMode |-> (cntQ[0] <= (IDXW+1)'(HALF) && cntQ[1] <= (IDXW+1)'(HALF)));

  // R3
  solo_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    !smtMode |-> cntQ[1] == '0);

  // R8
  exc_flush_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && !sel) |=> cntQ[0] == '0);

  // R8
  exc_flush_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && sel) |=> cntQ[1] == '0);

  // R9
  ext_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flushValid && flushThread) |=> cntQ[1] == '0);

endmodule

// File: rtl/retire_queue.sv
module retire_queue
  import rq_pkg::*;
#(
  parameter int DEPTH = 224,
  parameter int RW    = 8,
  parameter int NCMP  = 2,
  parameter int TAGW  = 8,
  localparam int IDXW = $clog2(DEPTH),
  localparam int HALF = DEPTH / 2,
  localparam int CW   = $clog2(RW + 1),
  localparam int PW   = $clog2(RW)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       smtMode,
  input  logic                       allocValid,
  input  logic                       allocThread,
  input  logic                       allocEnd,
  input  logic [TAGW-1:0]            allocPrevTag,
  output logic                       allocReady,
  output logic [IDXW-1:0]            allocIdx,
  input  logic [NCMP-1:0]            cmplValid,
  input  logic [NCMP-1:0][IDXW-1:0]  cmplIdx,
  input  logic [NCMP-1:0]            cmplExc,
  input  logic                       flushValid,
  input  logic                       flushThread,
  output logic [RW-1:0]              retValid,
  output logic [RW-1:0][TAGW-1:0]    retPrevTag,
  output logic                       retThread,
  output logic                       excValid,
  output logic                       excThread,
  output logic [IDXW-1:0]            excIdx
);

  rqStrobe_t                   st;
  logic [1:0][RW-1:0][IDXW-1:0] winIdx;
  logic [1:0][RW-1:0]           winOk, winExc, winEnd;
  logic [RW-1:0]                retMask;

  rq_ctrl #(
    .DEPTH(DEPTH), .RW(RW), .IDXW(IDXW), .HALF(HALF), .CW(CW), .PW(PW)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .smtMode(smtMode),
    .allocValid(allocValid), .allocThread(allocThread),
    .allocReady(allocReady), .allocIdx(allocIdx),
    .flushValid(flushValid), .flushThread(flushThread),
    .winOk(winOk), .winExc(winExc), .winEnd(winEnd),
    .winIdx(winIdx), .retMask(retMask), .st(st),
    .excValid(excValid), .excIdx(excIdx)
  );

  rq_data #(
    .DEPTH(DEPTH), .RW(RW), .NCMP(NCMP), .TAGW(TAGW), .IDXW(IDXW), .HALF(HALF)
  ) i_data (
    .clk(clk), .rstN(rstN), .smtMode(smtMode), .st(st),
    .allocIdx(allocIdx), .allocEnd(allocEnd), .allocTag(allocPrevTag),
    .winIdx(winIdx), .retMask(retMask),
    .cmplValid(cmplValid), .cmplIdx(cmplIdx), .cmplExc(cmplExc),
    .winOk(winOk), .winExc(winExc), .winEnd(winEnd), .retTag(retPrevTag)
  );

  assign retValid  = retMask;
  assign retThread = st.retThr;
  assign excThread = st.retThr;

endmodule

// File: tb/test_retire_queue.sv
module test_retire_queue;

  localparam int DEPTH = 224;
  localparam int RW    = 8;
  localparam int NCMP  = 2;
  localparam int TAGW  = 8;
  localparam int IDXW  = 8;
  localparam int HALF  = 112;

  logic                      clk = 1'b0;
  logic                      rstN = 1'b0;
  logic                      smtMode = 1'b0;
  logic                      allocValid = 1'b0, allocThread = 1'b0, allocEnd = 1'b0;
  logic [TAGW-1:0]           allocPrevTag = '0;
  logic                      allocReady;
  logic [IDXW-1:0]           allocIdx;
  logic [NCMP-1:0]           cmplValid = '0;
  logic [NCMP-1:0][IDXW-1:0] cmplIdx = '0;
  logic [NCMP-1:0]           cmplExc = '0;
  logic                      flushValid = 1'b0, flushThread = 1'b0;
  logic [RW-1:0]             retValid;
  logic [RW-1:0][TAGW-1:0]   retPrevTag;
  logic                      retThread, excValid, excThread;
  logic [IDXW-1:0]           excIdx;

  retire_queue #(.DEPTH(DEPTH), .RW(RW), .NCMP(NCMP), .TAGW(TAGW)) i_retire_queue (
    .clk(clk), .rstN(rstN), .smtMode(smtMode),
    .allocValid(allocValid), .allocThread(allocThread), .allocEnd(allocEnd),
    .allocPrevTag(allocPrevTag), .allocReady(allocReady), .allocIdx(allocIdx),
    .cmplValid(cmplValid), .cmplIdx(cmplIdx), .cmplExc(cmplExc),
    .flushValid(flushValid), .flushThread(flushThread),
    .retValid(retValid), .retPrevTag(retPrevTag), .retThread(retThread),
    .excValid(excValid), .excThread(excThread), .excIdx(excIdx)
  );

  always #10 clk = ~clk;  // 50 MHz

  int nChk = 0, nErr = 0;
  logic finished = 1'b0;
  logic [6:0] seqT [2];
  logic [6:0] expTag [2];
  logic endOf [256];
  int retCnt [2];
  int maxPer = 0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset(input logic m);
    @(negedge clk);
    rstN = 1'b0;
    smtMode = m;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    expTag[0] = seqT[0];
    expTag[1] = seqT[1];
    retCnt[0] = 0;
    retCnt[1] = 0;
  endtask

  task automatic doAlloc(input logic t, input logic e, output int idx, output logic rdy);
    @(negedge clk);
    allocValid = 1'b1; allocThread = t; allocEnd = e; allocPrevTag = {t, seqT[t]};
    #1;
    idx = int'(allocIdx);
    rdy = allocReady;
    if (rdy) begin
      endOf[{t, seqT[t]}] = e;
      seqT[t] = seqT[t] + 7'd1;
    end
    @(negedge clk);
    allocValid = 1'b0;
  endtask

  task automatic doCmpl(input int p, input int idx, input logic x);
    @(negedge clk);
    cmplValid[p] = 1'b1; cmplIdx[p] = IDXW'(idx); cmplExc[p] = x;
    @(negedge clk);
    cmplValid = '0; cmplExc = '0;
  endtask

  task automatic doFlush(input logic t);
    @(negedge clk);
    flushValid = 1'b1; flushThread = t;
    expTag[t] = seqT[t];
    @(negedge clk);
    flushValid = 1'b0;
  endtask

  // Retire monitor: order, contiguity, boundary, counts.
  always @(negedge clk) begin
    if (rstN && (|retValid)) begin
      int cnt;
      logic [TAGW-1:0] lastTag;
      cnt = 0;
      lastTag = '0;
      for (int k = 0; k < RW; k++) begin
        if (retValid[k]) begin
          cnt++;
          // R6 allocation order and displaced tag
          chk(retPrevTag[k] == {retThread, expTag[retThread]}, "R6 tag order",
              int'(retPrevTag[k]), int'({retThread, expTag[retThread]}));
          expTag[retThread] = expTag[retThread] + 7'd1;
          lastTag = retPrevTag[k];
        end
      end
      // R6 slots contiguous from 0
      chk(retValid == RW'((1 << cnt) - 1), "R6 contiguous slots", int'(retValid), (1 << cnt) - 1);
      // R5 group ends at an instruction boundary
      chk(endOf[lastTag] == 1'b1, "R5 group boundary", int'(endOf[lastTag]), 1);
      retCnt[retThread] += cnt;
      if (!retThread && cnt > maxPer) maxPer = cnt;
    end
  end

  typedef struct packed {
    int          n;
    logic [15:0] endm;
    logic [15:0] donem;
    int          expRet;
    int          expMax;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3,  16'h0004, 16'h0007, 3,  3},   // one 3-op instruction, all done
    '{3,  16'h0004, 16'h0003, 0,  0},   // last op missing: nothing leaves
    '{4,  16'h000A, 16'h0007, 2,  2},   // 2+2, second incomplete
    '{12, 16'h0FFF, 16'h0FFF, 12, 8},   // 12 singles: cap at 8
    '{10, 16'h0210, 16'h03FF, 10, 5},   // 5+5: group stops at boundary
    '{6,  16'h003F, 16'h003D, 1,  1},   // gap at op 1
    '{9,  16'h01FF, 16'h01FF, 9,  8},   // 9 singles
    '{8,  16'h0080, 16'h00FF, 8,  8}    // one full-width instruction
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nErr++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  end

  initial begin
    int idxArr [16];
    int idx, cnt, iA, iB, iC, i0, i1, base0;
    logic rdy;
    seqT[0] = '0; seqT[1] = '0;
    for (int i = 0; i < 256; i++) endOf[i] = 1'b0;

    // R11 reset state
    doReset(1'b0);
    #1;
    chk(allocReady == 1'b1, "R11 ready", int'(allocReady), 1);
    chk(allocIdx == '0, "R11 index", int'(allocIdx), 0);
    chk(retValid == '0, "R11 retValid", int'(retValid), 0);
    chk(excValid == 1'b0, "R11 excValid", int'(excValid), 0);

    // Table of instruction shapes, single-thread mode
    for (int v = 0; v < 8; v++) begin
      doFlush(1'b0);
      retCnt[0] = 0;
      maxPer = 0;
      for (int k = 0; k < VECS[v].n; k++) begin
        doAlloc(1'b0, VECS[v].endm[k], idxArr[k], rdy);
        // R1 consecutive indices from base 0
        chk(idxArr[k] == k && rdy, "R1 alloc index", idxArr[k], k);
      end
      for (int k = VECS[v].n - 1; k >= 0; k--) begin
        if (VECS[v].donem[k]) doCmpl(k % 2, idxArr[k], 1'b0);
      end
      repeat (4) @(negedge clk);
      // R5 whole complete instructions only
      chk(retCnt[0] == VECS[v].expRet, "R5 retired count", retCnt[0], VECS[v].expRet);
      // R7 per-cycle cap and boundary stop
      chk(maxPer == VECS[v].expMax, "R7 largest group", maxPer, VECS[v].expMax);
    end

    // R4 completion on the allocation edge is dropped
    doFlush(1'b0);
    retCnt[0] = 0;
    @(negedge clk);
    allocValid = 1'b1; allocThread = 1'b0; allocEnd = 1'b1; allocPrevTag = {1'b0, seqT[0]};
    cmplValid[0] = 1'b1; cmplIdx[0] = '0; cmplExc[0] = 1'b0;
    endOf[{1'b0, seqT[0]}] = 1'b1;
    seqT[0] = seqT[0] + 7'd1;
    @(negedge clk);
    allocValid = 1'b0; cmplValid = '0;
    repeat (3) @(negedge clk);
    chk(retCnt[0] == 0, "R4 racing completion dropped", retCnt[0], 0);
    doCmpl(0, 0, 1'b0);
    repeat (2) @(negedge clk);
    chk(retCnt[0] == 1, "R4 later completion taken", retCnt[0], 1);

    // R8 fault becomes visible once the oldest op completes
    doFlush(1'b0);
    retCnt[0] = 0;
    doAlloc(1'b0, 1'b0, iA, rdy);
    doAlloc(1'b0, 1'b1, iB, rdy);
    doAlloc(1'b0, 1'b1, iC, rdy);
    doCmpl(0, iB, 1'b1);
    doCmpl(1, iC, 1'b0);
    chk(excValid == 1'b0, "R8 no report while oldest incomplete", int'(excValid), 0);
    doCmpl(0, iA, 1'b0);
    #1;
    chk(excValid == 1'b1, "R8 report", int'(excValid), 1);
    chk(int'(excIdx) == iB, "R8 faulted index", int'(excIdx), iB);
    chk(excThread == 1'b0, "R8 thread", int'(excThread), 0);
    chk(retValid == '0, "R8 no retire with report", int'(retValid), 0);
    @(negedge clk);
    expTag[0] = seqT[0];
    doAlloc(1'b0, 1'b1, idx, rdy);
    chk(idx == 0, "R8 region discarded", idx, 0);
    doCmpl(0, idx, 1'b0);
    repeat (2) @(negedge clk);
    chk(retCnt[0] == 1, "R8 retire after discard", retCnt[0], 1);

    // R3 single-thread full capacity
    doReset(1'b0);
    cnt = 0;
    for (int k = 0; k < DEPTH + 1; k++) begin
      doAlloc(1'b0, 1'b0, idx, rdy);
      if (rdy) cnt++;
    end
    chk(cnt == DEPTH, "R3 full depth", cnt, DEPTH);
    doAlloc(1'b1, 1'b1, idx, rdy);
    chk(rdy == 1'b0, "R3 thread 1 refused", int'(rdy), 0);

    // R2 halved capacity per thread
    doReset(1'b1);
    cnt = 0;
    base0 = -1;
    for (int k = 0; k < HALF + 4; k++) begin
      doAlloc(1'b0, 1'b0, idx, rdy);
      if (rdy) begin
        if (base0 < 0) base0 = idx;
        cnt++;
      end
    end
    chk(cnt == HALF, "R2 thread 0 share", cnt, HALF);
    chk(base0 == 0, "R2 thread 0 base", base0, 0);
    doAlloc(1'b1, 1'b0, idx, rdy);
    chk(idx == HALF && rdy, "R2 thread 1 base", idx, HALF);

    // R10 alternation with both threads ready
    doReset(1'b1);
    doAlloc(1'b0, 1'b1, i0, rdy);
    doAlloc(1'b1, 1'b1, i1, rdy);
    @(negedge clk);
    cmplValid = 2'b11; cmplIdx[0] = IDXW'(i0); cmplIdx[1] = IDXW'(i1); cmplExc = '0;
    @(negedge clk);
    cmplValid = '0;
    #1;
    chk(retValid == RW'(1) && retThread == 1'b0, "R10 thread 0 first", int'(retThread), 0);
    @(negedge clk);
    #1;
    chk(retValid == RW'(1) && retThread == 1'b1, "R10 thread 1 next", int'(retThread), 1);
    @(negedge clk);
    chk(retCnt[0] == 1 && retCnt[1] == 1, "R10 one each", retCnt[0] + retCnt[1], 2);

    // R9 per-thread discard
    doAlloc(1'b0, 1'b1, iA, rdy);
    doAlloc(1'b0, 1'b1, iB, rdy);
    doAlloc(1'b1, 1'b1, idx, rdy);
    doAlloc(1'b1, 1'b1, idx, rdy);
    doFlush(1'b1);
    doAlloc(1'b1, 1'b1, idx, rdy);
    chk(idx == HALF, "R9 flushed thread at base", idx, HALF);
    doAlloc(1'b0, 1'b1, iC, rdy);
    chk(iC == iB + 1, "R9 other thread untouched", iC, iB + 1);
    retCnt[0] = 0;
    doCmpl(0, iA, 1'b0);
    doCmpl(1, iB, 1'b0);
    doCmpl(0, iC, 1'b0);
    repeat (2) @(negedge clk);
    chk(retCnt[0] == 3, "R9 other thread retires", retCnt[0], 3);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

endmodule